// File: doc/BRIEF.md
# Serial ADC Result Capture

This block sits in an FPGA next to a successive-approximation converter whose results arrive over a serial link. It drives the converter's active-low convert strobe and watches its active-low busy line. While busy is low, the converter sends a burst of data clocks, and the block samples the serial data line on each of them, most significant bit first. A conversion is requested with a one-cycle `start_i` pulse, or continuously while `free_run_i` is held high. Two limits govern when a strobe may be issued: a minimum gap between strobes, so that the input can be acquired, and the converter's busy state.

The word sent during a conversion is the result of the conversion before it. The block therefore commits a word only when busy returns high, and only when exactly sixteen bits were taken in. It suppresses the first frame after reset, because that frame carries no valid result. Each good word appears on a signed 16-bit bus together with a one-cycle valid strobe. A frame that ends with any other bit count is dropped, and a frame-error flag is raised and stays set until reset. The data clock, the serial data and the busy line are each passed through a synchronizer of the same depth, so that data and clock edges stay aligned inside the system clock domain.

Top module: `adc_serial_capture`

## Requirements
- R1: Each convert strobe holds `conv_n_o` low for exactly PULSE_CYC system clocks, then returns it high; at all other times it is high.
- R2: A strobe is issued only while a request is present (`start_i` high or `free_run_i` high), the converter is not busy, and at least SPACING_CYC clocks have passed since the previous strobe fell. With `free_run_i` held high and the converter idle, successive strobes fall exactly SPACING_CYC clocks apart. With no request, no strobe is issued.
- R3: A request made while `adc_busy_n_i` is low is dropped and not held over; once the frame finishes, no strobe follows from it.
- R4: Serial data is sampled on rising data-clock edges while busy is low. The first bit taken is bit 15 of the word and the last is bit 0, and `word_o` presents the word as a two's-complement value (16'h8000 is -32768, 16'h7FFF is +32767).
- R5: A word is committed only when busy rises after exactly 16 data-clock rising edges. `word_valid_o` then pulses high for a single clock, and it is never high at any other time.
- R6: The first frame to end after reset produces no `word_valid_o` pulse; every later frame of 16 bits does.
- R7: A frame that ends with a bit count other than 16 produces no valid pulse and sets `frame_err_o`, which stays high until reset.
- R8: When busy rises in the same instant as the sixteenth data-clock rising edge, that last bit is still taken, and the word is committed correctly.
- R9: While reset is asserted, `conv_n_o` is high, `word_valid_o` and `frame_err_o` are low, and `word_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single conversion request |
| free_run_i | input | 1 | Request conversions continuously while high |
| conv_n_o | output | 1 | Active-low convert strobe to the converter |
| adc_busy_n_i | input | 1 | Converter busy, low while converting and sending |
| adc_dclk_i | input | 1 | Data clock burst from the converter (asynchronous) |
| adc_sdata_i | input | 1 | Serial result data from the converter |
| word_o | output | 16 | Last committed result, signed |
| word_valid_o | output | 1 | One-cycle strobe marking a new word |
| frame_err_o | output | 1 | Sticky flag for a frame with a wrong bit count |

## Verification
The case that matters most is the end of a frame, where the last data-clock rising edge and the rise of busy fall in the same system-clock cycle. The shift and the commit then happen together, and the commit must see the word after the shift. The converter model in the bench brings this about by raising busy and the data clock in the same instant on every third frame of the free-running sweep. Because the three synchronizers have equal depth, both edges reach the capture logic in one cycle. The run is judged by comparing each committed word against the code the model sent one conversion earlier, and by a per-frame check that a valid strobe did or did not appear.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

    typedef enum logic [0:0] {
        CV_IDLE  = 1'b0,
        CV_PULSE = 1'b1
    } cv_state_e;

    // lane indices of the synchronizer bank
    localparam int LANE_DCLK  = 0;
    localparam int LANE_SDATA = 1;
    localparam int LANE_IDLE  = 2;
    localparam int N_LANES    = 3;

endpackage

// File: rtl/adc_cap_sync.sv
module adc_cap_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/adc_cap_convgen.sv
module adc_cap_convgen
    import adc_cap_pkg::*;
#(
    parameter int PULSE_CYC   = 10,
    parameter int SPACING_CYC = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic idle_i,
    output logic conv_n_o
);
    localparam int PW = $clog2(PULSE_CYC + 1);
    localparam int SW = $clog2(SPACING_CYC + 1);

    typedef struct packed {
        cv_state_e     st;
        logic          conv_n;
        logic [PW-1:0] pcnt;
        logic [SW-1:0] scnt;
    } cv_t;

    cv_t cv_d, cv_q;

    always_comb begin
        cv_d = cv_q;
        if (cv_q.scnt != '0) cv_d.scnt = cv_q.scnt - 1'b1;
        case (cv_q.st)
            CV_IDLE: begin
                if (req_i && idle_i && (cv_q.scnt == '0)) begin
                    cv_d.st     = CV_PULSE;
                    cv_d.conv_n = 1'b0;
                    cv_d.pcnt   = PW'(PULSE_CYC - 1);
                    cv_d.scnt   = SW'(SPACING_CYC - 1);
                end
            end
            default: begin
                if (cv_q.pcnt == '0) begin
                    cv_d.conv_n = 1'b1;
                    cv_d.st     = CV_IDLE;
                end else begin
                    cv_d.pcnt = cv_q.pcnt - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cv_q.st     <= CV_IDLE;
            cv_q.conv_n <= 1'b1;
            cv_q.pcnt   <= '0;
            cv_q.scnt   <= '0;
        end else begin
            cv_q <= cv_d;
        end
    end

    assign conv_n_o = cv_q.conv_n;
endmodule

// File: rtl/adc_cap_framer.sv
module adc_cap_framer #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dclk_s_i,
    input  logic              sdata_s_i,
    input  logic              idle_s_i,
    output logic [DATA_W-1:0] word_o,
    output logic              valid_o,
    output logic              err_o,
    output logic              idle_rise_o
);
    localparam int CW = $clog2(DATA_W + 2);

    typedef struct packed {
        logic              dclk_prev;
        logic              idle_prev;
        logic              primed;
        logic [CW-1:0]     cnt;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] word;
        logic              valid;
        logic              err;
    } fr_t;

    fr_t fr_d, fr_q;

    logic          dclk_rise, idle_fall, idle_rise, shift_en;
    logic [CW-1:0] cnt_base;

    always_comb begin
        dclk_rise = dclk_s_i & ~fr_q.dclk_prev;
        idle_fall = ~idle_s_i & fr_q.idle_prev;
        idle_rise = idle_s_i & ~fr_q.idle_prev;
        // take a bit while busy, including the edge that ends busy
        shift_en  = dclk_rise & ~(idle_s_i & fr_q.idle_prev);
        cnt_base  = idle_fall ? '0 : fr_q.cnt;

        fr_d           = fr_q;
        fr_d.valid     = 1'b0;
        fr_d.dclk_prev = dclk_s_i;
        fr_d.idle_prev = idle_s_i;
        fr_d.cnt       = cnt_base;

        if (shift_en) begin
            fr_d.sh = {fr_q.sh[DATA_W-2:0], sdata_s_i};
            if (cnt_base != CW'(DATA_W + 1)) fr_d.cnt = cnt_base + 1'b1;
        end

        if (idle_rise) begin
            fr_d.primed = 1'b1;
            if (fr_d.cnt == CW'(DATA_W)) begin
                if (fr_q.primed) begin
                    fr_d.word  = fr_d.sh;
                    fr_d.valid = 1'b1;
                end
            end else begin
                fr_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q.dclk_prev <= 1'b0;
            fr_q.idle_prev <= 1'b1;
            fr_q.primed    <= 1'b0;
            fr_q.cnt       <= '0;
            fr_q.sh        <= '0;
            fr_q.word      <= '0;
            fr_q.valid     <= 1'b0;
            fr_q.err       <= 1'b0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign word_o      = fr_q.word;
    assign valid_o     = fr_q.valid;
    assign err_o       = fr_q.err;
    assign idle_rise_o = idle_rise;
endmodule

// File: rtl/adc_serial_capture.sv
module adc_serial_capture
    import adc_cap_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int PULSE_CYC   = 10,
    parameter int SPACING_CYC = 5000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     free_run_i,
    output logic                     conv_n_o,
    input  logic                     adc_busy_n_i,
    input  logic                     adc_dclk_i,
    input  logic                     adc_sdata_i,
    output logic signed [DATA_W-1:0] word_o,
    output logic                     word_valid_o,
    output logic                     frame_err_o
);
    localparam logic [N_LANES-1:0] LANE_RST = N_LANES'(1) << LANE_IDLE;

    logic [N_LANES-1:0] lane_raw, lane_s;
    logic               idle_s, idle_rise;
    logic [DATA_W-1:0]  word_u;

    assign lane_raw[LANE_DCLK]  = adc_dclk_i;
    assign lane_raw[LANE_SDATA] = adc_sdata_i;
    assign lane_raw[LANE_IDLE]  = adc_busy_n_i;

    for (genvar g = 0; g < N_LANES; g++) begin : g_sync
        adc_cap_sync #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(LANE_RST[g])
        ) sync_i (
            .clk  (clk),
            .rst_n(rst_n),
            .d_i  (lane_raw[g]),
            .q_o  (lane_s[g])
        );
    end

    assign idle_s = lane_s[LANE_IDLE];

    adc_cap_convgen #(
        .PULSE_CYC  (PULSE_CYC),
        .SPACING_CYC(SPACING_CYC)
    ) convgen_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (start_i | free_run_i),
        .idle_i  (idle_s),
        .conv_n_o(conv_n_o)
    );

    adc_cap_framer #(
        .DATA_W(DATA_W)
    ) framer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .dclk_s_i   (lane_s[LANE_DCLK]),
        .sdata_s_i  (lane_s[LANE_SDATA]),
        .idle_s_i   (idle_s),
        .word_o     (word_u),
        .valid_o    (word_valid_o),
        .err_o      (frame_err_o),
        .idle_rise_o(idle_rise)
    );

    assign word_o = word_u;
endmodule

// File: rtl/adc_serial_capture_chk.sv
module adc_serial_capture_chk #(
    parameter int PULSE_CYC   = 10,
    parameter int SPACING_CYC = 5000
) (
    input logic clk,
    input logic rst_n,
    input logic conv_n,
    input logic idle_s,
    input logic idle_rise,
    input logic valid,
    input logic err
);
    logic [31:0] low_cnt_q, gap_cnt_q;
    logic        conv_prev_q, seen_fall_q;
    logic [1:0]  rise_cnt_q;
    logic        conv_fell;

    assign conv_fell = conv_prev_q & ~conv_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q   <= '0;
            gap_cnt_q   <= '0;
            conv_prev_q <= 1'b1;
            seen_fall_q <= 1'b0;
            rise_cnt_q  <= '0;
        end else begin
            conv_prev_q <= conv_n;
            low_cnt_q   <= conv_n ? '0 : low_cnt_q + 1;
            if (conv_fell) begin
                gap_cnt_q   <= 32'd1;
                seen_fall_q <= 1'b1;
            end else if (gap_cnt_q < 32'(SPACING_CYC)) begin
                gap_cnt_q <= gap_cnt_q + 1;
            end
            if (idle_rise && rise_cnt_q != 2'd3) rise_cnt_q <= rise_cnt_q + 1'b1;
        end
    end

    // R1: strobe width
    a_r1_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_n) |-> low_cnt_q == 32'(PULSE_CYC));

    // R2: minimum spacing between strobes
    a_r2_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_fell && seen_fall_q) |-> gap_cnt_q >= 32'(SPACING_CYC));

    // R3: no strobe launched while converter was busy
    a_r3_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_n) |-> $past(idle_s));

    // R5: valid is a single cycle and follows a busy rise
    a_r5_single_valid: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    a_r5_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(idle_rise));

    // R6: no word from the first frame after reset
    a_r6_first_frame: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> rise_cnt_q >= 2'd2);

    // R7: frame error is sticky
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

bind adc_serial_capture adc_serial_capture_chk #(
    .PULSE_CYC  (PULSE_CYC),
    .SPACING_CYC(SPACING_CYC)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .conv_n   (conv_n_o),
    .idle_s   (idle_s),
    .idle_rise(idle_rise),
    .valid    (word_valid_o),
    .err      (frame_err_o)
);

// File: tb/adc_serial_capture_tb_top.sv
`timescale 1ns/1ps
module adc_serial_capture_tb_top;
    localparam int PULSE = 10;
    localparam int SPACE = 200;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, free_run = 1'b0;
    logic busy_n = 1'b1, dclk = 1'b0, sdata = 1'b0;
    logic conv_n, valid, ferr;
    logic signed [15:0] word;

    adc_serial_capture #(
        .DATA_W(16), .SYNC_STAGES(2), .PULSE_CYC(PULSE), .SPACING_CYC(SPACE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .free_run_i(free_run),
        .conv_n_o(conv_n), .adc_busy_n_i(busy_n), .adc_dclk_i(dclk),
        .adc_sdata_i(sdata), .word_o(word), .word_valid_o(valid),
        .frame_err_o(ferr)
    );

    always #2.5 clk = ~clk;

    int nchk = 0, nfail = 0, cyc = 0;
    int k = 0, frames_done = 0, conv_falls = 0, valid_cnt = 0;
    int fall_cyc = -1, prev_fall_cyc = -1, nb = 16;
    bit prev_free = 0, short_mode = 0, collide_en = 0, collide_mode = 0;
    bit expect_valid = 0, got_valid = 0, prev_valid = 0;
    logic [15:0] exp_word = '0, tx = '0;

    always @(negedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] code(input int n);
        case (n % 16)
            3:       code = 16'h8000;
            4:       code = 16'h7FFF;
            5:       code = 16'hFFFF;
            6:       code = 16'h0000;
            default: code = 16'((n * 12345 + 7) & 16'hFFFF);
        endcase
    endfunction

    // strobe width and spacing (R1, R2)
    always @(negedge conv_n) if (rst_n) begin
        conv_falls++;
        if (prev_fall_cyc >= 0) begin
            chk(cyc - prev_fall_cyc >= SPACE, "R2", "strobe gap", cyc - prev_fall_cyc, SPACE);
            if (free_run && prev_free)
                chk(cyc - prev_fall_cyc == SPACE, "R2", "free-run gap", cyc - prev_fall_cyc, SPACE);
        end
        prev_fall_cyc = cyc;
        fall_cyc = cyc;
        prev_free = free_run;
    end

    always @(posedge conv_n) if (rst_n && fall_cyc >= 0)
        chk(cyc - fall_cyc == PULSE, "R1", "strobe width", cyc - fall_cyc, PULSE);

    // converter model: sends the previous conversion's code
    always begin
        @(negedge conv_n);
        if (rst_n) begin
            tx = (k == 0) ? 16'hDEAD : code(k - 1);
            exp_word = tx;
            expect_valid = (k >= 1) && !short_mode;
            collide_mode = collide_en && (k % 3 == 2);
            got_valid = 0;
            nb = short_mode ? 15 : 16;
            #30 busy_n = 1'b0;
            for (int b = 0; b < nb; b++) begin
                sdata = tx[15 - b];
                #20;
                if (b == nb - 1 && collide_mode) busy_n = 1'b1;
                dclk = 1'b1;
                #20 dclk = 1'b0;
            end
            if (!collide_mode) #15 busy_n = 1'b1;
            repeat (12) @(negedge clk);
            chk(got_valid == expect_valid,
                short_mode ? "R7" : (k == 0 ? "R6" : "R5"),
                "valid seen for frame", got_valid, expect_valid);
            k++;
            frames_done++;
        end
    end

    // output monitor (R4, R5, R8)
    always @(negedge clk) begin
        if (rst_n && valid) begin
            valid_cnt++;
            got_valid = 1;
            chk(expect_valid, "R5", "unexpected valid", 1, 0);
            chk(word == exp_word, collide_mode ? "R8" : "R4", "word", word, exp_word);
            chk(!prev_valid, "R5", "valid width", 2, 1);
        end
        prev_valid = rst_n && valid;
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(conv_n == 1'b1, "R9", "conv_n in reset", conv_n, 1);
        chk(valid == 1'b0, "R9", "valid in reset", valid, 0);
        chk(ferr == 1'b0, "R9", "err in reset", ferr, 0);
        chk(word == 16'sd0, "R9", "word in reset", word, 0);
        rst_n = 1'b1;

        // single start, first frame suppressed (R6)
        pulse_start();
        wait (frames_done == 1);
        repeat (300) @(negedge clk);
        chk(conv_falls == 1, "R2", "no request no strobe", conv_falls, 1);

        // free-running sweep with coincident end-of-frame edges (R4, R8)
        collide_en = 1;
        free_run = 1'b1;
        wait (frames_done == 13);
        free_run = 1'b0;
        collide_en = 0;
        repeat (300) @(negedge clk);
        chk(conv_falls == 13, "R2", "free-run strobes", conv_falls, 13);
        chk(valid_cnt == 12, "R5", "free-run words", valid_cnt, 12);

        // request during busy dropped (R3)
        pulse_start();
        wait (busy_n == 1'b0);
        pulse_start();
        wait (frames_done == 14);
        repeat (100) @(negedge clk);
        chk(conv_falls == 14, "R3", "busy request dropped", conv_falls, 14);

        // request inside spacing window dropped (R2)
        pulse_start();
        wait (frames_done == 15);
        pulse_start();
        repeat (100) @(negedge clk);
        chk(conv_falls == 15, "R2", "early request dropped", conv_falls, 15);

        // short frame (R7)
        repeat (100) @(negedge clk);
        short_mode = 1;
        pulse_start();
        wait (frames_done == 16);
        short_mode = 0;
        chk(ferr == 1'b1, "R7", "err after short frame", ferr, 1);
        repeat (300) @(negedge clk);
        pulse_start();
        wait (frames_done == 17);
        chk(ferr == 1'b1, "R7", "err sticky", ferr, 1);

        // reset again, first frame suppressed again (R9, R6)
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(ferr == 1'b0, "R9", "err cleared by reset", ferr, 0);
        chk(conv_n == 1'b1, "R9", "conv_n after reset", conv_n, 1);
        k = 0;
        prev_fall_cyc = -1;
        fall_cyc = -1;
        prev_free = 0;
        rst_n = 1'b1;
        pulse_start();
        wait (frames_done == 18);
        repeat (20) @(negedge clk);

        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected run completion");
        summary();
        $finish;
    end
endmodule